// File: doc/BRIEF.md
# Dual-Class Nested Interrupt Controller

This block gathers up to 28 interrupt request lines and presents them to a processor core as two request classes: a normal request (`irq_o`) and a fast request (`fiq_o`). Each class owns an enable register that is set and cleared through two separate write addresses, so firmware never needs a read-modify-write to change one source. Each class also has a masked-status register. Both classes, and every register, use one shared bit map. Bit 0 is not a source. Bits 7 and 9 are dead positions, and bit 1 is a software interrupt that firmware raises by a register write.

For the normal class, a vectored mode gives every source a 3-bit priority and always reports the winning pending source. When a control bit turns nesting on, reading the vector register acknowledges the winner and pushes its priority on a stack up to eight levels deep. A write to the end-of-service address pops one level. While the stack holds levels, `irq_o` is raised only for a source whose priority beats the level on top. The register bus is a plain word-addressed write/read strobe pair, and read data returns one cycle after the read strobe.

Top module: `intc_dual`

## Requirements
- R1: After reset both enable registers, the software interrupt bit, the nesting control bit, `nest_depth`, `irq_o`, `fiq_o` and `vec_valid` are all 0, and every priority is 0.
- R2: A write to address 1 (normal) or 4 (fast) sets the enable bits written as 1. A write to address 2 (normal) or 5 (fast) clears the enable bits written as 1. Zero bits leave enables unchanged. Reading address 1 or 4 returns the enables.
- R3: Bits 0, 7 and 9 can never be enabled as sources and never raise a request. Reading address 0 returns the normal masked status (synchronized requests AND normal enables). Reading address 3 returns the fast masked status in bits 27..1.
- R4: Bit 0 of the fast status read (address 3) is 1 exactly when any fast-class source bit is set.
- R5: Peripheral lines pass a two-flop synchronizer. `irq_o` and `fiq_o` are registered and reflect a line change on the third rising edge after it. With nesting off, `irq_o` is 1 whenever the normal status is non-zero, and `fiq_o` is 1 whenever the fast status is non-zero.
- R6: Input line 1 is ignored. Source 1 is a software bit at address 6: writing data bit 0 = 1 sets it, and writing data bit 1 = 1 clears it. Otherwise it holds its value, and reading address 6 returns it in bit 0.
- R7: Source i has a priority in word 16 + i/8, bits [4*(i%8)+2 : 4*(i%8)]. 0 is the most urgent level. `vec_id` gives the pending normal source with the lowest level, with ties going to the lower index. `vec_valid` shows that one is pending.
- R8: Address 7 bit 0 enables nesting. While it is 0, reading the vector register (address 9) does not change `nest_depth`.
- R9: With nesting on, a read of address 9 returns {depth in bits 9..6, valid in bit 5, winner index in bits 4..0}. When `irq_o` would be raised, the read also pushes the winner's priority. `irq_o` is then raised only if the winner's level is strictly below the level on top of the stack.
- R10: A write to address 8 pops one level. At depth 0 it has no effect.
- R11: `nest_depth` never exceeds 8. A push at depth 8 is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NSRC (28) | Level-sensitive peripheral request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW (5) | Word address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid the cycle after `bus_rd` |
| irq_o | output | 1 | Normal-class request to the core |
| fiq_o | output | 1 | Fast-class request to the core |
| vec_valid | output | 1 | A normal-class source is pending |
| vec_id | output | IW (5) | Index of the winning normal-class source |
| nest_depth | output | DEPTHW (4) | Number of stacked service levels |

## Verification
On every cycle, the assertions check the following:
- the stack depth stays within eight and moves by at most one level per cycle;
- a push grows the depth;
- a raised `irq_o` always has a valid vector behind it;
- the reported vector never names bit 0, 7 or 9.

Some behaviour is visible only in the bench's scenarios:
- the arithmetic of masking and the fast aggregate bit;
- set/clear semantics with zero bits;
- persistence of the software bit;
- tie-breaking between equal priorities;
- preemption against the stacked level;
- refusal of a ninth level.

These depend on the values written and on the order of events.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Register word addresses
  localparam int ADR_NSTAT = 0;
  localparam int ADR_NSET  = 1;
  localparam int ADR_NCLR  = 2;
  localparam int ADR_FSTAT = 3;
  localparam int ADR_FSET  = 4;
  localparam int ADR_FCLR  = 5;
  localparam int ADR_SOFT  = 6;
  localparam int ADR_CTRL  = 7;
  localparam int ADR_EOS   = 8;
  localparam int ADR_VEC   = 9;
  localparam int ADR_PRI   = 16;
  // Priority field layout: one nibble per source
  localparam int PRI_STRIDE = 4;
  // Bit map positions with fixed meaning
  localparam int BIT_AGG  = 0;
  localparam int BIT_SOFT = 1;
  localparam int BIT_RSV  = 7;
  localparam int BIT_NONE = 9;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int N  = 28,
  parameter int PW = 3,
  parameter int IW = 5
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] pri_flat,
  output logic            any,
  output logic [IW-1:0]   idx,
  output logic [PW-1:0]   best
);
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '1;
    // Scan downward so that on equal levels the lower index wins
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i] && (!any || (pri_flat[i*PW +: PW] <= best))) begin
        any  = 1'b1;
        idx  = IW'(i);
        best = pri_flat[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/intc_nest.sv
module intc_nest #(
  parameter int NEST   = 8,
  parameter int PW     = 3,
  parameter int DEPTHW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [PW-1:0]     push_pri,
  output logic [PW-1:0]     top_pri,
  output logic [DEPTHW-1:0] depth,
  output logic              full,
  output logic              empty
);
  localparam int IXW = (NEST > 1) ? $clog2(NEST) : 1;

  logic [PW-1:0]     mem [NEST];
  logic [DEPTHW-1:0] cnt_q;

  assign full    = (cnt_q == DEPTHW'(NEST));
  assign empty   = (cnt_q == '0);
  assign depth   = cnt_q;
  assign top_pri = mem[IXW'(cnt_q - 1'b1)];

  // Storage without reset so it maps onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (push && !full && !pop)
      mem[IXW'(cnt_q)] <= push_pri;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (pop && !empty)
      cnt_q <= cnt_q - 1'b1;
    else if (push && !full)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/intc_dual.sv
module intc_dual
  import intc_pkg::*;
#(
  parameter int NSRC   = 28,
  parameter int PW     = 3,
  parameter int NEST   = 8,
  parameter int AW     = 5,
  parameter int DW     = 32,
  parameter int IW     = $clog2(NSRC),
  parameter int DEPTHW = $clog2(NEST + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   irq_src,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              vec_valid,
  output logic [IW-1:0]     vec_id,
  output logic [DEPTHW-1:0] nest_depth
);
  localparam int FIELDS = DW / PRI_STRIDE;
  localparam logic [NSRC-1:0] LIVE =
    ~((NSRC'(1) << BIT_AGG) | (NSRC'(1) << BIT_RSV) | (NSRC'(1) << BIT_NONE));

  logic [NSRC-1:0]    sync_w, raw_w, nen_q, fen_q, nstat_w, fstat_w;
  logic [NSRC*PW-1:0] pri_flat;
  logic [PW-1:0]      pri_q [NSRC];
  logic               soft_q, nest_q;
  logic               any_w, allow_w, push_w, pop_w, full_w, empty_w;
  logic [IW-1:0]      idx_w;
  logic [PW-1:0]      best_w, top_w;
  logic [DEPTHW-1:0]  depth_w;
  logic [DW-1:0]      rd_word, pri_word;
  logic               unused_bits;

  assign unused_bits = ^bus_wdata;

  intc_sync #(.W(NSRC)) u_sync (.clk(clk), .rst(rst), .d(irq_src), .q(sync_w));

  always_comb begin
    raw_w = sync_w;
    raw_w[BIT_SOFT] = soft_q;
    raw_w = raw_w & LIVE;
  end
  assign nstat_w = raw_w & nen_q;
  assign fstat_w = raw_w & fen_q;

  function automatic logic hit(input logic [AW-1:0] a, input int r);
    return a == AW'(r);
  endfunction

  // Enables, software bit, control bit
  always_ff @(posedge clk) begin
    if (rst) begin
      nen_q  <= '0;
      fen_q  <= '0;
      soft_q <= 1'b0;
      nest_q <= 1'b0;
    end else if (bus_wr) begin
      if (hit(bus_addr, ADR_NSET)) nen_q <= nen_q | (bus_wdata[NSRC-1:0] & LIVE);
      if (hit(bus_addr, ADR_NCLR)) nen_q <= nen_q & ~bus_wdata[NSRC-1:0];
      if (hit(bus_addr, ADR_FSET)) fen_q <= fen_q | (bus_wdata[NSRC-1:0] & LIVE);
      if (hit(bus_addr, ADR_FCLR)) fen_q <= fen_q & ~bus_wdata[NSRC-1:0];
      if (hit(bus_addr, ADR_SOFT)) begin
        if (bus_wdata[1])      soft_q <= 1'b0;
        else if (bus_wdata[0]) soft_q <= 1'b1;
      end
      if (hit(bus_addr, ADR_CTRL)) nest_q <= bus_wdata[0];
    end
  end

  // Priority fields
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_pri
      always_ff @(posedge clk) begin
        if (rst)
          pri_q[i] <= '0;
        else if (bus_wr && hit(bus_addr, ADR_PRI + i / FIELDS))
          pri_q[i] <= bus_wdata[(i % FIELDS) * PRI_STRIDE +: PW];
      end
      assign pri_flat[i*PW +: PW] = pri_q[i];
    end
  endgenerate

  intc_arb #(.N(NSRC), .PW(PW), .IW(IW)) u_arb (
    .req(nstat_w), .pri_flat(pri_flat), .any(any_w), .idx(idx_w), .best(best_w)
  );

  assign allow_w = nest_q ? (any_w && (empty_w || (best_w < top_w))) : any_w;
  assign push_w  = bus_rd && hit(bus_addr, ADR_VEC) && nest_q && allow_w;
  assign pop_w   = bus_wr && hit(bus_addr, ADR_EOS);

  intc_nest #(.NEST(NEST), .PW(PW), .DEPTHW(DEPTHW)) u_nest (
    .clk(clk), .rst(rst), .push(push_w), .pop(pop_w), .push_pri(best_w),
    .top_pri(top_w), .depth(depth_w), .full(full_w), .empty(empty_w)
  );

  // Read mux
  always_comb begin
    pri_word = '0;
    for (int i = 0; i < NSRC; i++)
      if (hit(bus_addr, ADR_PRI + i / FIELDS))
        pri_word[(i % FIELDS) * PRI_STRIDE +: PW] = pri_q[i];
  end

  always_comb begin
    rd_word = '0;
    if      (hit(bus_addr, ADR_NSTAT)) rd_word[NSRC-1:0] = nstat_w;
    else if (hit(bus_addr, ADR_NSET))  rd_word[NSRC-1:0] = nen_q;
    else if (hit(bus_addr, ADR_FSTAT)) begin
      rd_word[NSRC-1:0] = fstat_w;
      rd_word[BIT_AGG]  = |fstat_w;
    end
    else if (hit(bus_addr, ADR_FSET))  rd_word[NSRC-1:0] = fen_q;
    else if (hit(bus_addr, ADR_SOFT))  rd_word[0] = soft_q;
    else if (hit(bus_addr, ADR_CTRL))  rd_word[0] = nest_q;
    else if (hit(bus_addr, ADR_VEC))   rd_word[IW+1+DEPTHW-1:0] = {depth_w, any_w, idx_w};
    else                               rd_word = pri_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
      vec_valid <= 1'b0;
      vec_id    <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_word;
      irq_o     <= allow_w;
      fiq_o     <= |fstat_w;
      vec_valid <= any_w;
      vec_id    <= idx_w;
    end
  end

  assign nest_depth = depth_w;
endmodule

// File: rtl/intc_dual_chk.sv
module intc_dual_chk #(
  parameter int NSRC   = 28,
  parameter int NEST   = 8,
  parameter int IW     = 5,
  parameter int DEPTHW = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_o,
  input logic              vec_valid,
  input logic [IW-1:0]     vec_id,
  input logic [DEPTHW-1:0] nest_depth,
  input logic              push,
  input logic              pop
);
  AST_DEPTH_CAP: assert property (@(posedge clk) disable iff (rst)
    nest_depth <= DEPTHW'(NEST)); // R11

  AST_DEPTH_STEP: assert property (@(posedge clk) disable iff (rst)
    (nest_depth == $past(nest_depth)) || (nest_depth == $past(nest_depth) + 1'b1) ||
    (nest_depth == $past(nest_depth) - 1'b1)); // R10

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && nest_depth < DEPTHW'(NEST)) |=> nest_depth == $past(nest_depth) + 1'b1); // R9

  AST_IRQ_HAS_VEC: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> vec_valid); // R5

  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec_id != 0 && vec_id != 7 && vec_id != 9 && vec_id < IW'(NSRC))); // R3
endmodule

bind intc_dual intc_dual_chk #(.NSRC(NSRC), .NEST(NEST), .IW(IW), .DEPTHW(DEPTHW)) u_chk (
  .clk(clk), .rst(rst), .irq_o(irq_o), .vec_valid(vec_valid), .vec_id(vec_id),
  .nest_depth(nest_depth), .push(push_w), .pop(pop_w)
);

// File: tb/intc_dual_test.sv
`timescale 1ns/1ps
module intc_dual_test;
  logic        clk = 0;
  logic        rst = 1;
  logic [27:0] irq_src = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o, vec_valid;
  logic [4:0]  vec_id;
  logic [3:0]  nest_depth;

  int errors = 0, checks = 0;
  logic [31:0] rdv;

  always #4 clk = ~clk;

  intc_dual uut (.*);

  // {src, normal enable, fast enable, exp normal status, exp fast status}
  localparam logic [27:0] TBL [0:3][0:4] = '{
    '{28'h00000F0, 28'hFFFFFFF, 28'h0000000, 28'h0000070, 28'h0000000},
    '{28'h0000A04, 28'h0000004, 28'h0000800, 28'h0000004, 28'h0000801},
    '{28'hFFFFFFF, 28'h0000000, 28'h0000283, 28'h0000000, 28'h0000000},
    '{28'h8000001, 28'h8000000, 28'h8000000, 28'h8000000, 28'h8000001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input int a);
    @(negedge clk); bus_rd = 1; bus_addr = 5'(a);
    @(negedge clk); bus_rd = 0; rdv = bus_rdata;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; irq_src = '0; waitn(3); rst = 0; waitn(1);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] pw [0:3];
    do_reset();
    // R1 reset state
    chk("R1 irq_o", 32'(irq_o), 0);
    chk("R1 fiq_o", 32'(fiq_o), 0);
    chk("R1 depth", 32'(nest_depth), 0);
    rd(1); chk("R1 nen", rdv, 0);
    rd(4); chk("R1 fen", rdv, 0);
    rd(7); chk("R1 ctrl", rdv, 0);
    rd(16); chk("R1 pri", rdv, 0);

    // Vector table: R3 R4 R5
    for (int k = 0; k < 4; k++) begin
      wr(2, 32'hFFFFFFFF); wr(5, 32'hFFFFFFFF);
      wr(1, 32'(TBL[k][1])); wr(4, 32'(TBL[k][2]));
      irq_src = TBL[k][0];
      waitn(4);
      rd(0); chk("R3 normal status", rdv, 32'(TBL[k][3]));
      rd(3); chk("R4 fast status", rdv, 32'(TBL[k][4]));
      chk("R5 irq_o", 32'(irq_o), 32'(TBL[k][3] != 0));
      chk("R5 fiq_o", 32'(fiq_o), 32'(TBL[k][4] != 0));
    end
    wr(2, 32'hFFFFFFFF); wr(5, 32'hFFFFFFFF); irq_src = '0; waitn(4);

    // R5 latency: third rising edge after the line change
    wr(1, 32'h0000010);
    @(negedge clk); irq_src = 28'h0000010;
    waitn(2); chk("R5 not yet", 32'(irq_o), 0);
    waitn(1); chk("R5 third edge", 32'(irq_o), 1);
    irq_src = '0; wr(2, 32'hFFFFFFFF); waitn(4);

    // R2 set/clear semantics
    wr(1, 32'h30); wr(1, 0); rd(1); chk("R2 set", rdv, 32'h30);
    wr(2, 32'h10); wr(2, 0); rd(1); chk("R2 clear", rdv, 32'h20);
    wr(1, 32'hFFFFFFFF); rd(1); chk("R3 dead bits", rdv, 32'hFFFFD7E);
    wr(2, 32'hFFFFFFFF);

    // R6 software bit
    wr(1, 32'h2);
    wr(6, 32'h1); waitn(3);
    rd(0); chk("R6 soft set", rdv, 32'h2);
    chk("R6 irq_o", 32'(irq_o), 1);
    waitn(10); rd(6); chk("R6 holds", rdv, 32'h1);
    wr(6, 32'h2); waitn(3);
    rd(0); chk("R6 cleared", rdv, 0);
    chk("R6 irq_o low", 32'(irq_o), 0);
    wr(2, 32'hFFFFFFFF);

    // R7 priority and tie break
    wr(1, 32'hFFFFFFF);
    irq_src = 28'h0001028; waitn(4);
    chk("R7 default tie", 32'(vec_id), 3);
    chk("R7 valid", 32'(vec_valid), 1);
    wr(16, (32'd2 << 12) | (32'd2 << 20));
    wr(17, 32'd1 << 16); waitn(2);
    chk("R7 lowest level", 32'(vec_id), 12);
    rd(17); chk("R7 pri readback", rdv, 32'd1 << 16);
    wr(17, 32'd2 << 16); waitn(2);
    chk("R7 equal levels", 32'(vec_id), 3);
    wr(17, 32'd1 << 16); waitn(2);

    // R8 nesting off: vector read does not push
    rd(9); waitn(2);
    chk("R8 depth", 32'(nest_depth), 0);
    chk("R8 irq_o", 32'(irq_o), 1);

    // R9 nesting on
    wr(7, 1); waitn(2);
    chk("R9 irq empty", 32'(irq_o), 1);
    rd(9); chk("R9 vec word", rdv, 32'h2C);
    waitn(2);
    chk("R9 depth1", 32'(nest_depth), 1);
    chk("R9 blocked equal", 32'(irq_o), 0);
    irq_src = irq_src | (28'd1 << 20); waitn(4);
    chk("R9 preempt", 32'(irq_o), 1);
    chk("R9 vec 20", 32'(vec_id), 20);
    rd(9); waitn(2);
    chk("R9 depth2", 32'(nest_depth), 2);
    chk("R9 blocked top0", 32'(irq_o), 0);

    // R10 pops
    wr(8, 0); waitn(2);
    chk("R10 pop depth", 32'(nest_depth), 1);
    chk("R10 irq after pop", 32'(irq_o), 1);
    irq_src = irq_src & ~(28'd1 << 20); waitn(4);
    chk("R10 irq equal", 32'(irq_o), 0);
    wr(8, 0); waitn(2);
    chk("R10 depth0", 32'(nest_depth), 0);
    chk("R10 irq empty", 32'(irq_o), 1);
    wr(8, 0); waitn(2);
    chk("R10 pop at empty", 32'(nest_depth), 0);

    // R11 eight levels then refusal
    do_reset();
    for (int w = 0; w < 4; w++) pw[w] = '0;
    for (int i = 10; i < 18; i++) pw[i / 8] = pw[i / 8] | (32'(17 - i) << (4 * (i % 8)));
    wr(17, pw[1]); wr(18, pw[2]);
    wr(1, 32'hFFFFFFF); wr(7, 1);
    for (int k = 0; k < 8; k++) begin
      irq_src = irq_src | (28'd1 << (10 + k)); waitn(4);
      chk("R11 irq before push", 32'(irq_o), 1);
      rd(9); waitn(2);
      chk("R11 depth", 32'(nest_depth), 32'(k + 1));
    end
    rd(9); waitn(2);
    chk("R11 refused", 32'(nest_depth), 8);
    chk("R11 irq blocked", 32'(irq_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule